// File: doc/BRIEF.md
# Mailbox Lock Controller with Transaction ID

This block guards a single shared command mailbox that several agents reach over a serial management bus. A send request takes the lock when it is free. Its passing completion code carries a 4-bit transaction ID, which the block generates internally. A later get request must present that ID to read the response. The lock stays held until the last bit of the read checksum has left the bus. If that transfer is cut short, the lock is kept and the get can be repeated.

A get that arrives before the response data is ready receives an abort-checksum indication and leaves the lock untouched. To stop a forgotten lock from blocking the mailbox for ever, the block counts the clock cycles in which the bus line is low while the lock is held. This count accumulates over separate low periods. When it reaches a parameterised threshold, the lock drops by itself. A configuration input turns this expiry off.

Completion codes are 8 bits wide. The upper nibble 0x4 means pass, and the lower nibble then carries the ID. 0x81 means busy and 0x80 means failed. Bus framing, checksum generation and payload handling sit outside this block.

Top module: `mbx_lock`

## Requirements
- R1: After reset the lock is free, `rd_active`, `cc_valid` and `abort_fcs` are 0, and the first ID granted will be 0.
- R2: A send request while the lock is free sets `lock_held` one cycle later. In that same cycle it pulses `cc_valid` with `cc_code` = 0x40 | ID, where ID (the low nibble) equals `lock_id`.
- R3: Each successful acquisition grants the previous ID plus one, modulo 16, so ID 15 is followed by ID 0. The ID does not depend on which agent sent the request.
- R4: A send request while the lock is held returns `cc_code` 0x81 and leaves `lock_held` and `lock_id` unchanged.
- R5: A get request whose ID differs from `lock_id`, or that arrives while no lock is held, returns `cc_code` 0x80 and changes no lock state. This includes a stale ID after a release or an expiry.
- R6: A get request with the matching ID while `rsp_ready` is 1 returns `cc_code` 0x40 | ID and sets `rd_active`. All of this happens one cycle later.
- R7: A get request with the matching ID while `rsp_ready` is 0 pulses `abort_fcs` with no `cc_valid`, and keeps the lock so that the get can be reissued.
- R8: The lock is released only by `fcs_last` while `rd_active` is 1. `fcs_last` with no read in progress is ignored.
- R9: `xfer_abort` during a read clears `rd_active` and keeps the lock, so a retried get with the same ID succeeds.
- R10: While the lock is held and `timeout_dis` is 0, every cycle with `bus_low` = 1 adds one to a counter. The counter restarts at each acquisition. The lock clears at the edge of the TIMEOUT_CYC-th low cycle, whether or not the low cycles were consecutive.
- R11: While `timeout_dis` is 1 the low-time count is frozen, and the lock persists however long the bus stays low.
- R12: If a send request and a get request arrive in the same cycle, only the send is served and the get has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_req | input | 1 | One-cycle send request (acquire) |
| get_req | input | 1 | One-cycle get request |
| get_id | input | 4 | Transaction ID presented with a get |
| rsp_ready | input | 1 | Response data is available |
| fcs_last | input | 1 | Last read-checksum bit has been transmitted |
| xfer_abort | input | 1 | Originator abandoned the read transfer |
| bus_low | input | 1 | Bus line is currently low |
| timeout_dis | input | 1 | 1 disables the low-time expiry |
| cc_valid | output | 1 | Completion code strobe |
| cc_code | output | 8 | Completion code |
| abort_fcs | output | 1 | Get answered with an abort checksum |
| rd_active | output | 1 | Response read in progress |
| lock_held | output | 1 | Mailbox lock is held |
| lock_id | output | 4 | ID of the current or most recent lock |

## Verification
A corrupted ID register shows up at the completion code of the very next acquisition, as a low nibble that breaks the plus-one sequence. It also shows up one cycle after a get that should match, as 0x80. A stuck or miscounting low-time counter moves the cycle in which `lock_held` falls away from the TIMEOUT_CYC-th low cycle. The bench therefore probes one cycle before and exactly at that threshold, after deliberately interrupted low periods. A wrong read-progress flag shows as a release with no read in progress, or as a lock kept after a completed checksum, in both cases within one cycle of `fcs_last`.

// File: rtl/mbx_lock.sv
module mbx_lock #(
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send_req,
  input  logic       get_req,
  input  logic [3:0] get_id,
  input  logic       rsp_ready,
  input  logic       fcs_last,
  input  logic       xfer_abort,
  input  logic       bus_low,
  input  logic       timeout_dis,
  output logic       cc_valid,
  output logic [7:0] cc_code,
  output logic       abort_fcs,
  output logic       rd_active,
  output logic       lock_held,
  output logic [3:0] lock_id
);
  localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [3:0] CC_PASS = 4'h4;
  localparam logic [7:0] CC_BUSY = 8'h81;
  localparam logic [7:0] CC_FAIL = 8'h80;

  logic [3:0]       next_id;
  logic [CNT_W-1:0] low_cnt;

  wire count_en = lock_held & ~timeout_dis & bus_low;
  wire expire   = count_en & (low_cnt == CNT_LAST);
  wire release_ = rd_active & fcs_last;
  wire drop     = release_ | expire;
  wire id_hit   = lock_held & ~drop & (get_id == lock_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_valid  <= 1'b0;
      cc_code   <= 8'h00;
      abort_fcs <= 1'b0;
      rd_active <= 1'b0;
      lock_held <= 1'b0;
      lock_id   <= 4'h0;
      next_id   <= 4'h0;
      low_cnt   <= '0;
    end else begin
      cc_valid  <= 1'b0;
      abort_fcs <= 1'b0;

      if (count_en && !expire) low_cnt <= low_cnt + 1'b1;

      if (rd_active && xfer_abort) rd_active <= 1'b0;

      if (drop) begin
        lock_held <= 1'b0;
        rd_active <= 1'b0;
      end

      if (send_req) begin
        cc_valid <= 1'b1;
        if (!lock_held) begin
          lock_held <= 1'b1;
          lock_id   <= next_id;
          next_id   <= next_id + 1'b1;
          low_cnt   <= '0;
          cc_code   <= {CC_PASS, next_id};
        end else begin
          cc_code   <= CC_BUSY;
        end
      end else if (get_req) begin
        if (id_hit) begin
          if (rsp_ready) begin
            cc_valid  <= 1'b1;
            cc_code   <= {CC_PASS, lock_id};
            rd_active <= 1'b1;
          end else begin
            abort_fcs <= 1'b1;
          end
        end else begin
          cc_valid <= 1'b1;
          cc_code  <= CC_FAIL;
        end
      end
    end
  end
endmodule

// File: rtl/mbx_lock_chk.sv
module mbx_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fcs_last,
  input logic       xfer_abort,
  input logic       bus_low,
  input logic       timeout_dis,
  input logic       cc_valid,
  input logic [7:0] cc_code,
  input logic       abort_fcs,
  input logic       rd_active,
  input logic       lock_held,
  input logic [3:0] lock_id
);
  logic       lock_q, have_prev;
  logic [3:0] prev_id;
  wire acq = lock_held & ~lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      have_prev <= 1'b0;
      prev_id   <= 4'h0;
    end else begin
      lock_q <= lock_held;
      if (acq) begin
        have_prev <= 1'b1;
        prev_id   <= lock_id;
      end
    end
  end

  assert_acq_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acq |-> cc_valid && cc_code == {4'h4, lock_id});

  assert_id_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acq && !have_prev |-> lock_id == 4'h0);

  assert_id_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acq && have_prev |-> lock_id == prev_id + 4'h1);

  assert_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cc_valid && cc_code == 8'h81 |-> lock_q && lock_held);

  assert_read_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> cc_valid && cc_code == {4'h4, lock_id});

  assert_abort_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_fcs |-> lock_held && !cc_valid);

  assert_drop_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && !lock_held |-> $past(rd_active && fcs_last) || $past(bus_low && !timeout_dis));

  assert_xabort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_active) && lock_held |-> $past(xfer_abort));

  assert_no_expiry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && !lock_held && $past(timeout_dis) |-> $past(fcs_last));
endmodule

bind mbx_lock mbx_lock_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fcs_last(fcs_last), .xfer_abort(xfer_abort),
  .bus_low(bus_low), .timeout_dis(timeout_dis), .cc_valid(cc_valid),
  .cc_code(cc_code), .abort_fcs(abort_fcs), .rd_active(rd_active),
  .lock_held(lock_held), .lock_id(lock_id)
);

// File: tb/mbx_lock_tb_top.sv
module mbx_lock_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic send_req = 0, get_req = 0, rsp_ready = 1, fcs_last = 0, xfer_abort = 0;
  logic bus_low = 0, timeout_dis = 0;
  logic [3:0] get_id = 0;
  logic cc_valid, abort_fcs, rd_active, lock_held;
  logic [7:0] cc_code;
  logic [3:0] lock_id;

  int n_chk = 0, n_fail = 0;
  logic [3:0] exp_id = 4'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_lock #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .send_req(send_req), .get_req(get_req),
    .get_id(get_id), .rsp_ready(rsp_ready), .fcs_last(fcs_last),
    .xfer_abort(xfer_abort), .bus_low(bus_low), .timeout_dis(timeout_dis),
    .cc_valid(cc_valid), .cc_code(cc_code), .abort_fcs(abort_fcs),
    .rd_active(rd_active), .lock_held(lock_held), .lock_id(lock_id)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_send();
    send_req = 1; @(negedge clk); send_req = 0;
  endtask

  task automatic do_get(input logic [3:0] id);
    get_id = id; get_req = 1; @(negedge clk); get_req = 0;
  endtask

  task automatic do_fcs();
    fcs_last = 1; @(negedge clk); fcs_last = 0;
  endtask

  task automatic do_xabort();
    xfer_abort = 1; @(negedge clk); xfer_abort = 0;
  endtask

  task automatic acquire(input string req);
    do_send();
    chk({req, " acquire cc_valid"}, cc_valid, 1);
    chk({req, " acquire code"}, cc_code, {4'h4, exp_id});
    chk({req, " acquire lock_id"}, lock_id, exp_id);
    chk({req, " acquire lock"}, lock_held, 1);
    exp_id = exp_id + 4'h1;
  endtask

  task automatic release_ok(input logic [3:0] id);
    do_get(id);
    chk("R6 get code", cc_code, {4'h4, id});
    chk("R6 rd_active", rd_active, 1);
    do_fcs();
    chk("R8 released", lock_held, 0);
  endtask

  task automatic t_reset();
    chk("R1 lock", lock_held, 0);
    chk("R1 rd_active", rd_active, 0);
    chk("R1 cc_valid", cc_valid, 0);
    chk("R1 abort", abort_fcs, 0);
  endtask

  task automatic t_basic();
    acquire("R2 R3");
    do_send();
    chk("R4 busy code", cc_code, 8'h81);
    chk("R4 lock kept", lock_held, 1);
    chk("R4 id kept", lock_id, 4'h0);
    do_get(4'h5);
    chk("R5 mismatch code", cc_code, 8'h80);
    chk("R5 lock kept", lock_held, 1);
    chk("R5 no read", rd_active, 0);
    rsp_ready = 0;
    do_get(4'h0);
    chk("R7 abort", abort_fcs, 1);
    chk("R7 no cc", cc_valid, 0);
    chk("R7 lock kept", lock_held, 1);
    rsp_ready = 1;
    do_get(4'h0);
    chk("R6 get code", cc_code, 8'h40);
    chk("R6 rd_active", rd_active, 1);
    do_xabort();
    chk("R9 read cleared", rd_active, 0);
    chk("R9 lock kept", lock_held, 1);
    do_fcs();
    chk("R8 idle fcs ignored", lock_held, 1);
    release_ok(4'h0);
    do_get(4'h0);
    chk("R5 stale code", cc_code, 8'h80);
  endtask

  task automatic t_sequence();
    for (int k = 0; k < 16; k++) begin
      logic [3:0] id;
      id = exp_id;
      acquire("R3 seq");
      release_ok(id);
    end
  endtask

  task automatic t_same_cycle();
    logic [3:0] id;
    id = exp_id;
    get_id = id; get_req = 1;
    acquire("R12");
    get_req = 0;
    chk("R12 get ignored", rd_active, 0);
    release_ok(id);
  endtask

  task automatic t_timeout();
    logic [3:0] id;
    id = exp_id;
    acquire("R10");
    bus_low = 1; idle(TMO - 1); bus_low = 0;
    chk("R10 held before threshold", lock_held, 1);
    idle(5);
    chk("R10 high time not counted", lock_held, 1);
    bus_low = 1; idle(1); bus_low = 0;
    chk("R10 expired", lock_held, 0);
    do_get(id);
    chk("R10 get after expiry", cc_code, 8'h80);
    acquire("R10 restart");
    bus_low = 1; idle(TMO - 1); bus_low = 0;
    chk("R10 counter restarted", lock_held, 1);
    bus_low = 1; idle(1); bus_low = 0;
    chk("R10 second expiry", lock_held, 0);
  endtask

  task automatic t_disabled();
    logic [3:0] id;
    id = exp_id;
    timeout_dis = 1;
    acquire("R11");
    bus_low = 1; idle(3 * TMO); bus_low = 0;
    chk("R11 lock persists", lock_held, 1);
    release_ok(id);
    timeout_dis = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset();
    t_basic();
    t_sequence();
    t_same_cycle();
    t_timeout();
    t_disabled();
    summary();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end
endmodule